// File: doc/BRIEF.md
# Multi-Channel Conversion Scan Sequencer

This block is the digital controller of a successive-approximation converter. It sits between a simple register bus and an external conversion engine. Software picks a conversion mode and a channel or group, then sets a start bit. The sequencer then requests conversions one at a time over a start/done handshake and stores each returned result in a per-channel data register. It raises a completion flag, and an interrupt when that is enabled.

There are four modes. Single mode converts one channel and then stops. The three scan modes cycle without pause over one, two or three groups of four channels. In the scan modes the completion flag is raised whenever a group finishes, while conversion carries on. A scan runs until software clears the start bit. The conversion that is already in flight is allowed to finish before the sequencer goes idle.

Top module: `adc_scan_sequencer`

## Requirements
- R1: After reset the status word (address 0) and the command word (address 1) both read 0, `irq` is 0 and `eng_start` is 0.
- R2: Mode code 00 is single mode. Setting the start bit (address 1, bit 0) issues exactly one conversion of the channel held in command bits 7:4, and a value above 11 selects channel 11. When that result arrives it is stored and readable at address 2+channel, the done flag (status bit 7) is set, and the start bit reads back 0.
- R3: Mode code 01 (status bits 5:4) scans one group in ascending order and wraps around: channels 4g to 4g+3, where g is command bits 7:6. A value of 3 for g selects group 2.
- R4: Mode code 10 scans channels 0 to 7 and mode code 11 scans channels 0 to 11, both in ascending order with wrap-around. Every result is stored at address 2+channel.
- R5: In a scan mode the done flag is set when the result of the last channel of a group (channel 3, 7 or 11) is stored, and the next conversion is requested at once.
- R6: Writing 0 to status bit 7 clears the done flag, and writing 1 leaves it unchanged. A hardware set in the same cycle as a clear wins.
- R7: `irq` equals done flag AND interrupt enable (status bit 6) in every cycle, including the cycle in which either of them changes.
- R8: While the start bit is 1, writes to the mode field and to command bits 7:4 are ignored.
- R9: After software clears the start bit during a scan, every requested conversion still completes and is stored, and no further `eng_start` is issued.
- R10: `eng_start` is high for exactly one cycle and carries a channel in the range 0 to 11. An `eng_done` that arrives while no conversion is outstanding changes no result and no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe; data appears on the next cycle |
| bus_addr | input | 4 | Register address: 0 status, 1 command, 2..13 results |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data from the last read, registered |
| eng_start | output | 1 | One-cycle conversion request |
| eng_ch | output | 4 | Channel to convert, valid with `eng_start` |
| eng_done | input | 1 | One-cycle completion from the engine |
| eng_result | input | 10 | Conversion result, valid with `eng_done` |
| irq | output | 1 | Interrupt request |

## Verification
The hardest situation to reach from the ports is a software write that lands on the same edge as the completion of a conversion. This covers a flag clear meeting a hardware set, and a stop meeting a group end. To reach the first case, the bench takes over the engine side by hand and drives the clear write and `eng_done` in the same cycle. Stops that coincide with a completion are reached through random stop times mixed with random engine latencies over many scan runs.

// File: rtl/adcs_pkg.sv
package adcs_pkg;
  typedef enum logic [1:0] {
    MODE_SINGLE = 2'b00,
    MODE_SCAN4  = 2'b01,
    MODE_SCAN8  = 2'b10,
    MODE_SCAN12 = 2'b11
  } scan_mode_e;

  typedef enum logic {
    SEQ_IDLE,
    SEQ_WAIT
  } seq_state_e;

  typedef enum logic [1:0] {
    RD_NONE,
    RD_WORD,
    RD_RES
  } rd_sel_e;
endpackage

// File: rtl/adcs_ctrl_regs.sv
module adcs_ctrl_regs
  import adcs_pkg::*;
#(
  parameter int CH_W = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_status,
  input  logic            wr_cmd,
  input  logic            wd_done,
  input  logic            wd_ie,
  input  logic [1:0]      wd_mode,
  input  logic            wd_start,
  input  logic [CH_W-1:0] wd_chsel,
  input  logic            set_done,
  input  logic            clr_start,
  output logic            done_q,
  output logic            ie_q,
  output scan_mode_e      mode_q,
  output logic            start_q,
  output logic [CH_W-1:0] chsel_q,
  output logic            irq_q
);
  logic done_n, ie_n;

  always_comb begin
    done_n = done_q;
    if (wr_status && !wd_done) done_n = 1'b0;
    if (set_done) done_n = 1'b1;
    ie_n = wr_status ? wd_ie : ie_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      done_q  <= 1'b0;
      ie_q    <= 1'b0;
      irq_q   <= 1'b0;
      mode_q  <= MODE_SINGLE;
      start_q <= 1'b0;
      chsel_q <= '0;
    end else begin
      done_q <= done_n;
      ie_q   <= ie_n;
      irq_q  <= done_n && ie_n;
      if (wr_status && !start_q) mode_q <= scan_mode_e'(wd_mode);
      if (wr_cmd) begin
        start_q <= wd_start;
        if (!start_q) chsel_q <= wd_chsel;
      end
      if (clr_start) start_q <= 1'b0;
    end
  end

  AST_IRQ_FOLLOWS_FLAGS: assert property (@(posedge clk) disable iff (rst)
    irq_q == (done_q && ie_q)); // R7
  AST_DONE_ONLY_FROM_HW: assert property (@(posedge clk) disable iff (rst)
    $rose(done_q) |-> $past(set_done)); // R6
  AST_MODE_HELD_WHILE_RUN: assert property (@(posedge clk) disable iff (rst)
    $past(start_q) |-> ($stable(mode_q) && $stable(chsel_q))); // R8
endmodule

// File: rtl/adcs_sequencer.sv
module adcs_sequencer
  import adcs_pkg::*;
#(
  parameter int NUM_CH = 12,
  parameter int GRP_SZ = 4,
  parameter int CH_W   = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start_q,
  input  scan_mode_e      mode_q,
  input  logic [CH_W-1:0] chsel_q,
  input  logic            eng_done,
  output logic            eng_start,
  output logic [CH_W-1:0] eng_ch,
  output logic            res_we,
  output logic            set_done,
  output logic            clr_start
);
  localparam int GRP_W   = $clog2(GRP_SZ);
  localparam int NUM_GRP = NUM_CH / GRP_SZ;
  localparam int LAST_CH = NUM_CH - 1;

  seq_state_e            st_q;
  logic                  single_q, start_pulse_q;
  logic [CH_W-1:0]       cur_q, first_q, last_q, first_n, last_n;
  logic [CH_W-GRP_W-1:0] grp;
  logic                  accept, grp_end;

  always_comb begin
    grp = chsel_q[CH_W-1:GRP_W];
    if (int'(grp) >= NUM_GRP) grp = (CH_W-GRP_W)'(NUM_GRP - 1);
    case (mode_q)
      MODE_SINGLE: begin
        first_n = (int'(chsel_q) > LAST_CH) ? CH_W'(LAST_CH) : chsel_q;
        last_n  = first_n;
      end
      MODE_SCAN4: begin
        first_n = {grp, {GRP_W{1'b0}}};
        last_n  = {grp, {GRP_W{1'b1}}};
      end
      MODE_SCAN8: begin
        first_n = '0;
        last_n  = CH_W'(2 * GRP_SZ - 1);
      end
      default: begin
        first_n = '0;
        last_n  = CH_W'(LAST_CH);
      end
    endcase
  end

  assign accept    = (st_q == SEQ_WAIT) && eng_done && !start_pulse_q;
  assign grp_end   = &cur_q[GRP_W-1:0];
  assign res_we    = accept;
  assign set_done  = accept && (single_q || grp_end);
  assign clr_start = accept && single_q;
  assign eng_start = start_pulse_q;
  assign eng_ch    = cur_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q          <= SEQ_IDLE;
      single_q      <= 1'b0;
      start_pulse_q <= 1'b0;
      cur_q         <= '0;
      first_q       <= '0;
      last_q        <= '0;
    end else begin
      start_pulse_q <= 1'b0;
      case (st_q)
        SEQ_IDLE: if (start_q) begin
          single_q      <= (mode_q == MODE_SINGLE);
          first_q       <= first_n;
          last_q        <= last_n;
          cur_q         <= first_n;
          start_pulse_q <= 1'b1;
          st_q          <= SEQ_WAIT;
        end
        default: if (accept) begin
          if (!single_q && start_q) begin
            cur_q         <= (cur_q == last_q) ? first_q : cur_q + 1'b1;
            start_pulse_q <= 1'b1;
          end else begin
            st_q <= SEQ_IDLE;
          end
        end
      endcase
    end
  end

  AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    start_pulse_q |=> !start_pulse_q); // R10
  AST_CHANNEL_LEGAL: assert property (@(posedge clk) disable iff (rst)
    start_pulse_q |-> (int'(cur_q) <= LAST_CH)); // R10
  AST_STOPPED_NO_START: assert property (@(posedge clk) disable iff (rst)
    (st_q == SEQ_IDLE && !start_q) |=> !start_pulse_q); // R9
  AST_SINGLE_DROPS_START: assert property (@(posedge clk) disable iff (rst)
    clr_start |=> (st_q == SEQ_IDLE && !start_q)); // R2
endmodule

// File: rtl/adcs_result_ram.sv
module adcs_result_ram #(
  parameter int NUM_CH = 12,
  parameter int RES_W  = 10,
  parameter int CH_W   = 4
) (
  input  logic             clk,
  input  logic             we,
  input  logic [CH_W-1:0]  waddr,
  input  logic [RES_W-1:0] wdata,
  input  logic             re,
  input  logic [CH_W-1:0]  raddr,
  output logic [RES_W-1:0] rdata_q
);
  logic [RES_W-1:0] mem [NUM_CH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata_q <= mem[raddr];
  end
endmodule

// File: rtl/adc_scan_sequencer.sv
module adc_scan_sequencer
  import adcs_pkg::*;
#(
  parameter int NUM_CH = 12,
  parameter int GRP_SZ = 4,
  parameter int RES_W  = 10,
  parameter int CH_W   = 4,
  parameter int ADDR_W = 4,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              eng_start,
  output logic [CH_W-1:0]   eng_ch,
  input  logic              eng_done,
  input  logic [RES_W-1:0]  eng_result,
  output logic              irq
);
  localparam int STATUS_ADDR = 0;
  localparam int CMD_ADDR    = 1;
  localparam int RES_BASE    = 2;
  localparam int DONE_BIT    = 7;
  localparam int IE_BIT      = 6;
  localparam int MODE_LSB    = 4;
  localparam int CHSEL_LSB   = 4;

  logic            wr_status, wr_cmd, res_hit, res_we, set_done, clr_start;
  logic            done_q, ie_q, start_q;
  scan_mode_e      mode_q;
  logic [CH_W-1:0] chsel_q, res_idx;
  logic [RES_W-1:0] ram_q;
  logic [DATA_W-1:0] status_w, cmd_w, word_q;
  rd_sel_e         rsel_q;
  logic            unused_wbits;

  assign wr_status = bus_wr && (bus_addr == ADDR_W'(STATUS_ADDR));
  assign wr_cmd    = bus_wr && (bus_addr == ADDR_W'(CMD_ADDR));
  assign res_hit   = (bus_addr >= ADDR_W'(RES_BASE)) &&
                     (bus_addr < ADDR_W'(RES_BASE + NUM_CH));
  assign res_idx   = CH_W'(bus_addr - ADDR_W'(RES_BASE));
  assign unused_wbits = ^{bus_wdata[DATA_W-1:CHSEL_LSB+CH_W], bus_wdata[3:1]};

  adcs_ctrl_regs #(.CH_W(CH_W)) u_regs (
    .clk(clk), .rst(rst), .wr_status(wr_status), .wr_cmd(wr_cmd),
    .wd_done(bus_wdata[DONE_BIT]), .wd_ie(bus_wdata[IE_BIT]),
    .wd_mode(bus_wdata[MODE_LSB+1:MODE_LSB]), .wd_start(bus_wdata[0]),
    .wd_chsel(bus_wdata[CHSEL_LSB+CH_W-1:CHSEL_LSB]),
    .set_done(set_done), .clr_start(clr_start),
    .done_q(done_q), .ie_q(ie_q), .mode_q(mode_q), .start_q(start_q),
    .chsel_q(chsel_q), .irq_q(irq)
  );

  adcs_sequencer #(.NUM_CH(NUM_CH), .GRP_SZ(GRP_SZ), .CH_W(CH_W)) u_seq (
    .clk(clk), .rst(rst), .start_q(start_q), .mode_q(mode_q),
    .chsel_q(chsel_q), .eng_done(eng_done), .eng_start(eng_start),
    .eng_ch(eng_ch), .res_we(res_we), .set_done(set_done),
    .clr_start(clr_start)
  );

  adcs_result_ram #(.NUM_CH(NUM_CH), .RES_W(RES_W), .CH_W(CH_W)) u_ram (
    .clk(clk), .we(res_we), .waddr(eng_ch), .wdata(eng_result),
    .re(bus_rd && res_hit), .raddr(res_idx), .rdata_q(ram_q)
  );

  always_comb begin
    status_w = '0;
    status_w[DONE_BIT] = done_q;
    status_w[IE_BIT]   = ie_q;
    status_w[MODE_LSB+1:MODE_LSB] = mode_q;
    cmd_w = '0;
    cmd_w[CHSEL_LSB+CH_W-1:CHSEL_LSB] = chsel_q;
    cmd_w[0] = start_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsel_q <= RD_NONE;
      word_q <= '0;
    end else if (bus_rd) begin
      if (res_hit) begin
        rsel_q <= RD_RES;
      end else begin
        rsel_q <= RD_WORD;
        if (bus_addr == ADDR_W'(STATUS_ADDR))   word_q <= status_w;
        else if (bus_addr == ADDR_W'(CMD_ADDR)) word_q <= cmd_w;
        else                                     word_q <= '0;
      end
    end
  end

  assign bus_rdata = (rsel_q == RD_RES) ? DATA_W'(ram_q) : word_q;

  AST_RESULT_WRITE_IN_RUN: assert property (@(posedge clk) disable iff (rst)
    res_we |-> (int'(eng_ch) < NUM_CH)); // R4
endmodule

// File: tb/adc_scan_sequencer_bench.sv
module adc_scan_sequencer_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst = 1'b1;
  logic bus_wr = 0, bus_rd = 0;
  logic [3:0] bus_addr = '0;
  logic [15:0] bus_wdata = '0, bus_rdata;
  logic eng_start, eng_done = 0, irq;
  logic [3:0] eng_ch;
  logic [9:0] eng_result = '0;

  int checks = 0, fails = 0, starts = 0, dones = 0;
  int rfirst = 0, rlast = 0, nxt_ch = 0, cur_mode = 0;
  bit exp_flag = 0, ie_b = 0, auto_en = 1, prev_start = 0, finished = 0;
  logic [9:0] shadow [12];
  bit converted [12];

  adc_scan_sequencer u_adc_scan_sequencer (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .eng_start(eng_start), .eng_ch(eng_ch), .eng_done(eng_done),
    .eng_result(eng_result), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  // expected channel order from the requirements
  function automatic void set_range(input int mode, input int chsel);
    int g;
    cur_mode = mode;
    case (mode)
      0: begin rfirst = (chsel > 11) ? 11 : chsel; rlast = rfirst; end
      1: begin g = chsel / 4; if (g > 2) g = 2; rfirst = 4*g; rlast = 4*g + 3; end
      2: begin rfirst = 0; rlast = 7; end
      default: begin rfirst = 0; rlast = 11; end
    endcase
    nxt_ch = rfirst;
  endfunction

  function automatic string mode_req(input int mode);
    return (mode == 0) ? "R2" : (mode == 1) ? "R3" : "R4";
  endfunction

  // request monitor
  always @(negedge clk) begin
    if (!rst) begin
      if (eng_start) begin
        starts++;
        chk("R10", "start pulse width", int'(prev_start), 0);
        chk(mode_req(cur_mode), "channel order", int'(eng_ch), nxt_ch);
        nxt_ch = (nxt_ch == rlast) ? rfirst : nxt_ch + 1;
      end
      prev_start = eng_start;
    end
  end

  // engine model
  initial begin
    int my_ch, lat;
    bit drv;
    drv = 0;
    my_ch = 0;
    forever begin
      @(negedge clk);
      if (drv) begin
        eng_done = 0;
        drv = 0;
        dones++;
        if (cur_mode == 0 || my_ch % 4 == 3) exp_flag = 1;
        chk((cur_mode != 0 && my_ch % 4 == 3) ? "R5" : "R7", "irq after result",
            int'(irq), int'(exp_flag && ie_b));
      end
      if (auto_en && eng_start) begin
        my_ch = int'(eng_ch);
        lat = $urandom_range(1, 4);
        repeat (lat) @(negedge clk);
        eng_result = 10'($urandom);
        shadow[my_ch] = eng_result;
        converted[my_ch] = 1;
        eng_done = 1;
        drv = 1;
      end
    end
  end

  task automatic bus_write(input int a, input int d);
    @(negedge clk);
    bus_wr = 1; bus_addr = 4'(a); bus_wdata = 16'(d);
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic bus_read(input int a, output int d);
    @(negedge clk);
    bus_rd = 1; bus_addr = 4'(a);
    @(negedge clk);
    bus_rd = 0;
    d = int'(bus_rdata);
  endtask

  task automatic check_results();
    int d;
    for (int c = 0; c < 12; c++) begin
      if (converted[c]) begin
        bus_read(2 + c, d);
        chk("R4", $sformatf("result ch%0d", c), d, int'(shadow[c]));
      end
    end
  endtask

  task automatic run_single(input int chsel, input int ie);
    int d, tries;
    bus_write(0, ie << 6);
    exp_flag = 0; ie_b = ie[0];
    set_range(0, chsel);
    bus_write(1, (chsel << 4) | 1);
    tries = 0;
    do begin bus_read(1, d); tries++; end while ((d & 1) && tries < 50);
    chk("R2", "start self-clear", d & 1, 0);
    bus_read(0, d);
    chk("R2", "done flag single", (d >> 7) & 1, 1);
    bus_read(2 + rfirst, d);
    chk("R2", "single result", d, int'(shadow[rfirst]));
    chk("R7", "irq single", int'(irq), ie);
  endtask

  task automatic run_scan(input int mode, input int chsel, input int ie, input int ncyc);
    int d, s0, s1;
    bus_write(0, (ie << 6) | (mode << 4));
    exp_flag = 0; ie_b = ie[0];
    set_range(mode, chsel);
    s0 = starts;
    bus_write(1, (chsel << 4) | 1);
    repeat (ncyc) @(negedge clk);
    bus_write(0, 32'h80 | (ie << 6) | (((~mode) & 3) << 4));
    bus_write(1, (((~chsel) & 15) << 4) | 1);
    bus_read(0, d);
    chk("R8", "mode held", (d >> 4) & 3, mode);
    bus_read(1, d);
    chk("R8", "chsel held", (d >> 4) & 15, chsel);
    bus_write(1, chsel << 4);
    repeat (40) @(negedge clk);
    s1 = starts;
    repeat (20) @(negedge clk);
    chk("R9", "no start after stop", starts, s1);
    chk("R9", "all requests done", dones, starts);
    chk("R9", "scan ran", int'(starts > s0 + 1), 1);
    bus_read(0, d);
    chk("R5", "done flag scan", (d >> 7) & 1, int'(exp_flag));
    check_results();
  endtask

  initial begin
    int d, m;
    void'($urandom(32'h5EED));
    for (int c = 0; c < 12; c++) begin shadow[c] = '0; converted[c] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 0;
    chk("R1", "irq reset", int'(irq), 0);
    chk("R1", "start reset", int'(eng_start), 0);
    bus_read(0, d); chk("R1", "status reset", d, 0);
    bus_read(1, d); chk("R1", "command reset", d, 0);

    // directed corner cases
    run_single(6, 1);
    run_single(14, 0);                 // R2: above 11 maps to 11
    run_scan(1, 13, 1, 60);            // R3: group 3 maps to group 2
    run_scan(3, 0, 1, 100);            // R4, R5
    run_scan(2, 0, 0, 50);

    // R6: hardware set and software clear on the same edge
    auto_en = 0;
    bus_write(0, 0); exp_flag = 0; ie_b = 0;
    set_range(0, 5);
    m = starts;
    bus_write(1, (5 << 4) | 1);
    while (starts == m) @(negedge clk);
    @(negedge clk);
    bus_wr = 1; bus_addr = 4'd0; bus_wdata = 16'h0000;
    eng_done = 1; eng_result = 10'h2A5;
    shadow[5] = 10'h2A5; converted[5] = 1;
    @(negedge clk);
    bus_wr = 0; eng_done = 0; dones++;
    bus_read(0, d); chk("R6", "set wins over clear", (d >> 7) & 1, 1);
    bus_write(0, 0);
    bus_read(0, d); chk("R6", "write 0 clears", (d >> 7) & 1, 0);
    bus_write(0, 32'h80);
    bus_read(0, d); chk("R6", "write 1 no effect", (d >> 7) & 1, 0);

    // R10: stray completion while idle
    @(negedge clk); eng_done = 1; eng_result = 10'h111;
    @(negedge clk); eng_done = 0;
    bus_read(0, d); chk("R10", "stray done flag", (d >> 7) & 1, 0);
    bus_read(2 + 5, d); chk("R10", "stray done result", d, 32'h2A5);
    auto_en = 1;

    // R7: interrupt follows enable and flag
    run_single(3, 0);
    chk("R7", "irq masked", int'(irq), 0);
    bus_write(0, 32'hC0);
    chk("R7", "irq on enable", int'(irq), 1);
    bus_write(0, 32'h40);
    chk("R7", "irq on clear", int'(irq), 0);

    // random runs
    for (int i = 0; i < 14; i++) begin
      int mode, chsel, ie;
      mode = $urandom_range(0, 3);
      chsel = $urandom_range(0, 15);
      ie = $urandom_range(0, 1);
      if (mode == 0) run_single(chsel, ie);
      else run_scan(mode, chsel, ie, $urandom_range(10, 120));
    end
    check_results();
    repeat (5) @(negedge clk);
    finish_run();
  end
endmodule